// File: doc/BRIEF.md
# De Bruijn Sequence Shift Generator

This block is an N-bit binary shift register whose state walks through every one of the 2^N possible N-bit values, including all-zero, before it repeats. Its linear part is a maximal-length Fibonacci LFSR built from a primitive polynomial over GF(2). That part alone has period 2^N-1 and never reaches the all-zero state. A single nonlinear correction term in the feedback closes that gap. The correction is the NOR of the N-1 register bits nearest the feedback input, and it is XORed into the linear feedback. This splices the all-zero state into the cycle. In the output stream, the run of N-1 zeros becomes a run of N zeros.

The register moves one position per enabled clock. It can be cleared by reset or loaded with any seed, and it cannot lock up from any starting value. The serial output is the oldest register bit, so the bit stream is a binary De Bruijn sequence of order N. Each N-bit pattern appears exactly once per period as a window of consecutive output bits.

Top module: `debruijn_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `state` to all-zero on that edge, overriding load and enable.
- R2: With `rst` low and `load` high at a clock edge, `state` takes the value of `seed` on that edge, whatever `en` is.
- R3: With `rst`, `load` and `en` all low at a clock edge, `state` keeps its value.
- R4: An enabled step (`en` high, `rst` and `load` low) moves the register one place toward the MSB: the new `state[N-1:1]` equals the old `state[N-2:0]`.
- R5: On an enabled step, the new `state[0]` is the XOR of the state bits selected by the ones in `TAPS`, further XORed with the NOR of `state[N-2:0]`. The default `TAPS` for N=8 selects bits 7, 5, 4 and 3.
- R6: With the default taps, an enabled step from the state with only bit N-1 set goes to all-zero, and an enabled step from all-zero goes to the state with only bit 0 set.
- R7: Starting from the reset state, the state first returns to its start value after exactly 2^N enabled steps, and each of the 2^N values is visited once in that period.
- R8: Over one period, the 2^N cyclic windows of N consecutive `sout` bits are pairwise distinct.
- R9: `sout` always equals `state[N-1]`. After an enabled step it therefore carries the old `state[N-2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to all-zero, active high |
| en | input | 1 | Advance the register one step |
| load | input | 1 | Replace the state with `seed`; has priority over `en` |
| seed | input | N | Value loaded when `load` is high |
| state | output | N | Full register contents |
| sout | output | 1 | Serial output, the register MSB |

## Verification
The bound checker covers the purely local, cycle-to-cycle behaviour on every edge:
- reset clears the register;
- a load copies the seed;
- a disabled cycle holds the state;
- an enabled step shifts the register and forms the new LSB from the tap XOR and the zero-detect term;
- the two splice transitions around all-zero are taken.

Properties of a whole period cannot be seen one edge at a time. These are the exact period length, each state visited once, and the distinct output windows. Only the bench's full-period scenarios can show them.

// File: rtl/debruijn_pkg.sv
package debruijn_pkg;
   // Register operation chosen each cycle, highest priority first in decode
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } dbg_op_e;

   // Priority decode of the control inputs
   function automatic dbg_op_e decode_op(input logic rst, input logic load, input logic en);
      if (rst)       return OP_CLEAR;
      else if (load) return OP_LOAD;
      else if (en)   return OP_SHIFT;
      else           return OP_HOLD;
   endfunction
endpackage

// File: rtl/dbg_tap_xor.sv
module dbg_tap_xor #(
   parameter int          N    = 8,
   parameter logic [N-1:0] TAPS = 8'hB8
) (
   input  logic [N-1:0] s,
   output logic         lin_fb
);
   logic [N-1:0] term;

   for (genvar i = 0; i < N; i++) begin : g_tap
      localparam logic SEL = TAPS[i];
      assign term[i] = s[i] & SEL;
   end

   assign lin_fb = ^term;
endmodule

// File: rtl/dbg_zero_detect.sv
module dbg_zero_detect #(
   parameter int W     = 7,
   parameter int GROUP = 4   // 0: flat reduction, else OR groups of this size first
) (
   input  logic [W-1:0] bits,
   output logic         all_zero
);
   if (GROUP == 0 || GROUP >= W) begin : g_flat
      assign all_zero = ~|bits;
   end else begin : g_grouped
      localparam int NG = (W + GROUP - 1) / GROUP;
      localparam int PW = NG * GROUP;
      logic [PW-1:0] padded;
      logic [NG-1:0] grp_any;

      assign padded = {{(PW-W){1'b0}}, bits};
      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign grp_any[g] = |padded[g*GROUP +: GROUP];
      end
      assign all_zero = ~|grp_any;
   end
endmodule

// File: rtl/dbg_state_reg.sv
module dbg_state_reg
   import debruijn_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  dbg_op_e      op,
   input  logic [N-1:0] seed,
   input  logic         fb,
   output logic [N-1:0] q
);
   always_ff @(posedge clk) begin
      unique case (op)
         OP_CLEAR: q <= '0;
         OP_LOAD:  q <= seed;
         OP_SHIFT: q <= {q[N-2:0], fb};
         default:  q <= q;
      endcase
   end
endmodule

// File: rtl/debruijn_gen.sv
module debruijn_gen
   import debruijn_pkg::*;
#(
   parameter int           N          = 8,
   parameter logic [N-1:0] TAPS       = 8'hB8,
   parameter int           ZDET_GROUP = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         load,
   input  logic [N-1:0] seed,
   output logic [N-1:0] state,
   output logic         sout
);
   localparam int LOW_W = N - 1;

   // Elaboration-time parameter checks
   if (N < 3) begin : g_bad_n
      $error("debruijn_gen: N must be at least 3");
   end
   if (TAPS[N-1] != 1'b1) begin : g_bad_taps
      $error("debruijn_gen: TAPS must include the MSB for an invertible map");
   end
   if (ZDET_GROUP < 0) begin : g_bad_group
      $error("debruijn_gen: ZDET_GROUP must not be negative");
   end

   logic    lin_fb;
   logic    low_zero;
   logic    fb;
   dbg_op_e op;

   dbg_tap_xor #(.N(N), .TAPS(TAPS)) u_taps (
      .s      (state),
      .lin_fb (lin_fb)
   );

   dbg_zero_detect #(.W(LOW_W), .GROUP(ZDET_GROUP)) u_zdet (
      .bits     (state[LOW_W-1:0]),
      .all_zero (low_zero)
   );

   assign fb = lin_fb ^ low_zero;
   assign op = decode_op(rst, load, en);

   dbg_state_reg #(.N(N)) u_reg (
      .clk  (clk),
      .op   (op),
      .seed (seed),
      .fb   (fb),
      .q    (state)
   );

   assign sout = state[N-1];
endmodule

// File: rtl/debruijn_gen_chk.sv
module debruijn_gen_chk #(
   parameter int           N    = 8,
   parameter logic [N-1:0] TAPS = 8'hB8
) (
   input logic         clk,
   input logic         rst,
   input logic         en,
   input logic         load,
   input logic [N-1:0] seed,
   input logic [N-1:0] state,
   input logic         sout
);
   logic step;
   assign step = en && !load && !rst;

   // R1
   a_r1_reset_zero: assert property (@(posedge clk) rst |=> state == '0);

   // R2
   a_r2_load_seed: assert property (@(posedge clk) disable iff (rst)
      load |=> state == $past(seed));

   // R3
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      (!load && !en) |=> $stable(state));

   // R4
   a_r4_shift: assert property (@(posedge clk) disable iff (rst)
      step |=> state[N-1:1] == $past(state[N-2:0]));

   // R5
   a_r5_feedback: assert property (@(posedge clk) disable iff (rst)
      step |=> state[0] == $past((^(state & TAPS)) ^ (~|state[N-2:0])));

   // R6: leaving all-zero
   a_r6_from_zero: assert property (@(posedge clk) disable iff (rst)
      (step && state == '0) |=> state == {{(N-1){1'b0}}, 1'b1});

   // R6: entering all-zero
   a_r6_to_zero: assert property (@(posedge clk) disable iff (rst)
      (step && state == {1'b1, {(N-1){1'b0}}}) |=> state == '0);

   // R9
   a_r9_serial_out: assert property (@(posedge clk) disable iff (rst)
      step |=> sout == $past(state[N-2]));
endmodule

bind debruijn_gen debruijn_gen_chk #(.N(N), .TAPS(TAPS)) u_chk (.*);

// File: tb/tb_debruijn_gen.sv
`timescale 1ns/100ps
module tb_debruijn_gen;
   localparam int           N    = 8;
   localparam logic [N-1:0] TAPS = 8'hB8;
   localparam int           P    = 1 << N;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en = 1'b0;
   logic         load = 1'b0;
   logic [N-1:0] seed = '0;
   logic [N-1:0] state;
   logic         sout;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   debruijn_gen #(.N(N), .TAPS(TAPS)) dut (
      .clk(clk), .rst(rst), .en(en), .load(load),
      .seed(seed), .state(state), .sout(sout)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock edge, then settle
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [N-1:0] model_next(input logic [N-1:0] s);
      logic f;
      f = (^(s & TAPS)) ^ (~|s[N-2:0]);
      return {s[N-2:0], f};
   endfunction

   task automatic t_reset();
      rst = 1; load = 1; en = 1; seed = 8'h5A;
      tick();
      check("R1 reset clears", state, '0);
      rst = 0; load = 0; en = 0;
   endtask

   task automatic t_hold();
      load = 1; seed = 8'h3C; tick();
      load = 0; en = 0;
      tick(); tick();
      check("R3 hold", state, 8'h3C);
      check("R9 sout is msb", sout, 1'b0);
   endtask

   task automatic t_load_priority();
      load = 1; en = 1; seed = 8'hC3; tick();
      check("R2 load over enable", state, 8'hC3);
      load = 0; en = 1; tick();
      check("R4 shift", state[N-1:1], 7'h43);
      check("R9 sout after step", sout, 1'b1);
      en = 0;
   endtask

   task automatic t_feedback();
      logic [N-1:0] seeds [4] = '{8'h01, 8'hFF, 8'h96, 8'h7E};
      for (int k = 0; k < 4; k++) begin
         load = 1; seed = seeds[k]; tick();
         load = 0; en = 1; tick(); en = 0;
         check("R5 feedback", state, model_next(seeds[k]));
      end
   endtask

   task automatic t_splice();
      load = 1; seed = 8'h80; tick();
      load = 0; en = 1; tick();
      check("R6 into zero", state, 8'h00);
      tick();
      check("R6 out of zero", state, 8'h01);
      en = 0;
   endtask

   task automatic t_period_windows();
      bit           seen [P];
      bit           bits [P];
      bit           wseen [P];
      logic [N-1:0] start;
      rst = 1; tick(); rst = 0;
      start = state;
      for (int i = 0; i < P; i++) seen[i] = 0;
      for (int i = 0; i < P; i++) wseen[i] = 0;
      en = 1;
      for (int k = 1; k <= P; k++) begin
         seen[state] = 1;
         bits[k-1] = sout;
         tick();
         if (k < P && state == start)
            check("R7 early return", k, P);
      end
      en = 0;
      check("R7 return at 2^N", state, start);
      begin
         int missing = 0;
         for (int i = 0; i < P; i++) if (!seen[i]) missing++;
         check("R7 all states seen", missing, 0);
      end
      begin
         int dup = 0;
         for (int k = 0; k < P; k++) begin
            int w = 0;
            for (int j = 0; j < N; j++) w = (w << 1) | int'(bits[(k + j) % P]);
            if (wseen[w]) dup++;
            wseen[w] = 1;
         end
         check("R8 distinct windows", dup, 0);
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset();
      t_hold();
      t_load_priority();
      t_feedback();
      t_splice();
      t_period_windows();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule